// File: doc/BRIEF.md
# Shift-Rotate Unit with Carry and Overflow Chaining

This unit executes the shift, rotate and byte-exchange group of a 16-bit processor. Each issued operation takes one operand word, an operation code, an amount of one or two bit positions, and the current carry and overflow flags. One clock later it presents the result word together with updated carry, overflow, sign and zero flags. The operation is applied whenever the issue strobe is high. Between issues, all outputs keep their last values.

For a two-position move, the shift-into-carry forms place both bits that leave the word into carry and overflow. The rotate forms take their fill bits back from those two flags, in mirrored order. Wider values can therefore be shifted one 16-bit half at a time: a shift-into-carry on one half followed by a rotate on the other half gives a 32-bit shift by one or two positions. The unit also checks the operand's register index, because only the lowest four registers may feed it. It raises a non-interruptible marker for every operation it executes.

Top module: `sru_top`

## Requirements
- R1: Operation codes: 0 logical left, 1 logical right, 2 arithmetic right, 3 byte exchange, 4 logical left into carry, 5 arithmetic right into carry, 6 rotate left through flags, 7 rotate right through flags. `amt_two_i` = 0 moves one position and 1 moves two. Codes 0, 1 and 4 fill the vacated positions with zeros.
- R2: Codes 2 and 5 fill the vacated high positions with copies of operand bit 15.
- R3: Code 3 with one position exchanges the two bytes of the operand. With two positions, the low byte is copied into both bytes of the result.
- R4: Code 4 sends operand bit 15 to carry, and with two positions also sends bit 14 to overflow. Code 5 sends bit 0 to carry, and with two positions also sends bit 1 to overflow. With one position, overflow is unchanged.
- R5: Code 6 with one position gives {operand[14:0], carry}. With two positions it gives {operand[13:0], carry, overflow}. Code 7 with one position gives {carry, operand[15:1]}, and with two positions gives {overflow, carry, operand[15:2]}. Codes 6 and 7 update carry and overflow as codes 4 and 5 do.
- R6: Codes 0 to 3 return carry and overflow unchanged from the inputs.
- R7: The sign output equals result bit 15, and the zero output is 1 exactly when the result is 0.
- R8: The illegal output is 1 when the issued register index is 4 to 7, and 0 when it is 0 to 3.
- R9: The non-interruptible output is 1 in the cycle after each issue and 0 after a cycle without issue.
- R10: Results and flags appear one clock after issue. When no operation is issued, they hold their values.
- R11: While reset is asserted, every output is 0.
- R12: A two-position shift into carry on one half of a 32-bit value, followed by a rotate on the other half that is fed the returned flags, gives the 32-bit shift by two in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_i | input | 1 | Execute the presented operation this cycle |
| op_i | input | 3 | Operation code (R1) |
| amt_two_i | input | 1 | 0: one position, 1: two positions |
| operand_i | input | 16 | Operand word |
| c_i | input | 1 | Incoming carry flag |
| o_i | input | 1 | Incoming overflow flag |
| reg_idx_i | input | 3 | Register index of the operand |
| result_o | output | 16 | Result word |
| c_o | output | 1 | Updated carry |
| o_o | output | 1 | Updated overflow |
| s_o | output | 1 | Sign flag |
| z_o | output | 1 | Zero flag |
| illegal_o | output | 1 | Register index outside 0 to 3 |
| no_irq_o | output | 1 | Non-interruptible marker |

## Verification
The hardest case to reach is the chained 32-bit shift. The flags that the first half returns have to go back into the second operation unchanged, with the bit order mirrored correctly. No single random operation can show an error in that order. The bench therefore runs dedicated two-step sequences that feed the carry and overflow outputs of a shift into carry back into a rotate, in both directions. It compares the two halves against a 32-bit shift computed arithmetically. Random operations then cover every code and amount with arbitrary incoming flags and register indices.

// File: rtl/sru_pkg.sv
package sru_pkg;

  typedef enum logic [2:0] {
    SR_SHL   = 3'd0,
    SR_SHR   = 3'd1,
    SR_ASR   = 3'd2,
    SR_BSWAP = 3'd3,
    SR_SHLC  = 3'd4,
    SR_ASRC  = 3'd5,
    SR_ROL   = 3'd6,
    SR_ROR   = 3'd7
  } sr_op_e;

  typedef struct packed {
    logic c;
    logic o;
  } sr_cv_t;

  function automatic logic sr_moves_left(sr_op_e op);
    return (op == SR_SHLC) || (op == SR_ROL);
  endfunction

  function automatic logic sr_moves_right(sr_op_e op);
    return (op == SR_ASRC) || (op == SR_ROR);
  endfunction

endpackage

// File: rtl/sru_shift_core.sv
module sru_shift_core
  import sru_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  sr_op_e         op,
  input  logic           two,
  input  logic [W-1:0]   a,
  input  sr_cv_t         cv_in,
  output logic [W-1:0]   res
);
  localparam int unsigned H = W / 2;

  logic [W-1:0] swap_one;
  logic [W-1:0] swap_two;

  // Byte exchange lanes: one lane per bit of the low half.
  for (genvar i = 0; i < H; i++) begin : g_lane
    assign swap_one[i]     = a[i + H];
    assign swap_one[i + H] = a[i];
    assign swap_two[i]     = a[i];
    assign swap_two[i + H] = a[i];
  end

  always_comb begin
    res = a;
    unique case (op)
      SR_SHL, SR_SHLC:
        res = two ? {a[W-3:0], 2'b00} : {a[W-2:0], 1'b0};
      SR_SHR:
        res = two ? {2'b00, a[W-1:2]} : {1'b0, a[W-1:1]};
      SR_ASR, SR_ASRC:
        res = two ? {{2{a[W-1]}}, a[W-1:2]} : {a[W-1], a[W-1:1]};
      SR_BSWAP:
        res = two ? swap_two : swap_one;
      SR_ROL:
        res = two ? {a[W-3:0], cv_in.c, cv_in.o} : {a[W-2:0], cv_in.c};
      SR_ROR:
        res = two ? {cv_in.o, cv_in.c, a[W-1:2]} : {cv_in.c, a[W-1:1]};
      default: res = a;
    endcase
  end

endmodule

// File: rtl/sru_flag_unit.sv
module sru_flag_unit
  import sru_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  sr_op_e         op,
  input  logic           two,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   res,
  input  sr_cv_t         cv_in,
  output sr_cv_t         cv_out,
  output logic           sign,
  output logic           zero
);

  always_comb begin
    cv_out = cv_in;
    if (sr_moves_left(op)) begin
      cv_out.c = a[W-1];
      if (two) cv_out.o = a[W-2];
    end else if (sr_moves_right(op)) begin
      cv_out.c = a[0];
      if (two) cv_out.o = a[1];
    end
  end

  assign sign = res[W-1];
  assign zero = ~|res;

endmodule

// File: rtl/sru_reg_guard.sv
module sru_reg_guard #(
  parameter int unsigned IDX_W     = 3,
  parameter int unsigned NUM_LEGAL = 4
) (
  input  logic [IDX_W-1:0] idx,
  output logic             illegal
);
  localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(NUM_LEGAL);

  assign illegal = ({1'b0, idx} >= LIMIT);

endmodule

// File: rtl/sru_top.sv
module sru_top
  import sru_pkg::*;
#(
  parameter int unsigned W         = 16,
  parameter int unsigned IDX_W     = 3,
  parameter int unsigned NUM_LEGAL = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue_i,
  input  logic [2:0]       op_i,
  input  logic             amt_two_i,
  input  logic [W-1:0]     operand_i,
  input  logic             c_i,
  input  logic             o_i,
  input  logic [IDX_W-1:0] reg_idx_i,
  output logic [W-1:0]     result_o,
  output logic             c_o,
  output logic             o_o,
  output logic             s_o,
  output logic             z_o,
  output logic             illegal_o,
  output logic             no_irq_o
);

  sr_op_e       op;
  sr_cv_t       cv_in;
  sr_cv_t       cv_nxt;
  logic [W-1:0] res_nxt;
  logic         sign_nxt;
  logic         zero_nxt;
  logic         ill_nxt;

  assign op    = sr_op_e'(op_i);
  assign cv_in = '{c: c_i, o: o_i};

  sru_shift_core #(.W(W)) u_core (
    .op    (op),
    .two   (amt_two_i),
    .a     (operand_i),
    .cv_in (cv_in),
    .res   (res_nxt)
  );

  sru_flag_unit #(.W(W)) u_flags (
    .op     (op),
    .two    (amt_two_i),
    .a      (operand_i),
    .res    (res_nxt),
    .cv_in  (cv_in),
    .cv_out (cv_nxt),
    .sign   (sign_nxt),
    .zero   (zero_nxt)
  );

  sru_reg_guard #(.IDX_W(IDX_W), .NUM_LEGAL(NUM_LEGAL)) u_guard (
    .idx     (reg_idx_i),
    .illegal (ill_nxt)
  );

  // Output stage: data loaded under the issue enable; marker every cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_o  <= '0;
      c_o       <= 1'b0;
      o_o       <= 1'b0;
      s_o       <= 1'b0;
      z_o       <= 1'b0;
      illegal_o <= 1'b0;
    end else if (issue_i) begin
      result_o  <= res_nxt;
      c_o       <= cv_nxt.c;
      o_o       <= cv_nxt.o;
      s_o       <= sign_nxt;
      z_o       <= zero_nxt;
      illegal_o <= ill_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) no_irq_o <= 1'b0;
    else        no_irq_o <= issue_i;
  end

endmodule

// File: rtl/sru_checker.sv
module sru_checker #(
  parameter int unsigned W     = 16,
  parameter int unsigned IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             issue_i,
  input logic [2:0]       op_i,
  input logic             amt_two_i,
  input logic [W-1:0]     operand_i,
  input logic             c_i,
  input logic             o_i,
  input logic [IDX_W-1:0] reg_idx_i,
  input logic [W-1:0]     result_o,
  input logic             c_o,
  input logic             o_o,
  input logic             s_o,
  input logic             z_o,
  input logic             illegal_o,
  input logic             no_irq_o
);

  AST_MARKER_AFTER_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i |=> no_irq_o); // R9

  AST_MARKER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_i |=> !no_irq_o); // R9

  AST_PLAIN_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && !op_i[2]) |=> (c_o == $past(c_i)) && (o_o == $past(o_i))); // R6

  AST_LEFT_CARRY_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && op_i == 3'd4) |=> (c_o == $past(operand_i[W-1]))); // R4

  AST_RIGHT_CARRY_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && op_i == 3'd5) |=> (c_o == $past(operand_i[0]))); // R4

  AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    no_irq_o |-> (z_o == (result_o == '0))); // R7

  AST_ILLEGAL_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i |=> (illegal_o == ($past(reg_idx_i) >= IDX_W'(4)))); // R8

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_i |=> $stable(result_o) && $stable(c_o) && $stable(o_o)); // R10

  AST_SIGN_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    no_irq_o |-> (s_o == result_o[W-1])); // R7

endmodule

bind sru_top sru_checker #(.W(W), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .issue_i   (issue_i),
  .op_i      (op_i),
  .amt_two_i (amt_two_i),
  .operand_i (operand_i),
  .c_i       (c_i),
  .o_i       (o_i),
  .reg_idx_i (reg_idx_i),
  .result_o  (result_o),
  .c_o       (c_o),
  .o_o       (o_o),
  .s_o       (s_o),
  .z_o       (z_o),
  .illegal_o (illegal_o),
  .no_irq_o  (no_irq_o)
);

// File: tb/sim_sru_top.sv
module sim_sru_top;

  logic        clk;
  logic        rst_n;
  logic        issue_i;
  logic [2:0]  op_i;
  logic        amt_two_i;
  logic [15:0] operand_i;
  logic        c_i;
  logic        o_i;
  logic [2:0]  reg_idx_i;
  logic [15:0] result_o;
  logic        c_o, o_o, s_o, z_o, illegal_o, no_irq_o;

  int n_cmp = 0;
  int n_bad = 0;

  // Reference state: what the outputs must show after the last edge.
  logic [15:0] e_res;
  logic        e_c, e_o, e_s, e_z, e_ill, e_nirq;

  sru_top u0 (
    .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .op_i(op_i),
    .amt_two_i(amt_two_i), .operand_i(operand_i), .c_i(c_i), .o_i(o_i),
    .reg_idx_i(reg_idx_i), .result_o(result_o), .c_o(c_o), .o_o(o_o),
    .s_o(s_o), .z_o(z_o), .illegal_o(illegal_o), .no_irq_o(no_irq_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [2:0] op);
    case (op)
      3'd0, 3'd1: return "R1";
      3'd2:       return "R2";
      3'd3:       return "R3";
      3'd4, 3'd5: return "R4";
      default:    return "R5";
    endcase
  endfunction

  // Behavioural model of one operation.
  task automatic model(input logic [2:0] op, input logic two,
                       input logic [15:0] a, input logic ci, input logic oi,
                       output logic [15:0] r, output logic co, output logic oo);
    int n;
    n  = two ? 2 : 1;
    co = ci;
    oo = oi;
    case (op)
      3'd0, 3'd4: r = a << n;
      3'd1:       r = a >> n;
      3'd2, 3'd5: r = 16'($signed(a) >>> n);
      3'd3:       r = two ? {a[7:0], a[7:0]} : {a[7:0], a[15:8]};
      3'd6:       r = two ? 16'((32'(a) << 2) | (32'(ci) << 1) | 32'(oi))
                          : 16'((32'(a) << 1) | 32'(ci));
      default:    r = two ? ((a >> 2) | (16'(oi) << 15) | (16'(ci) << 14))
                          : ((a >> 1) | (16'(ci) << 15));
    endcase
    if (op == 3'd4 || op == 3'd6) begin
      co = a[15];
      if (two) oo = a[14];
    end else if (op == 3'd5 || op == 3'd7) begin
      co = a[0];
      if (two) oo = a[1];
    end
  endtask

  task automatic compare_all(input string rtag, input string ftag);
    chk(rtag, "result", result_o, e_res);
    chk(ftag, "carry", 16'(c_o), 16'(e_c));
    chk(ftag, "overflow", 16'(o_o), 16'(e_o));
    chk("R7", "sign", 16'(s_o), 16'(e_s));
    chk("R7", "zero", 16'(z_o), 16'(e_z));
    chk("R8", "illegal", 16'(illegal_o), 16'(e_ill));
    chk("R9", "noirq", 16'(no_irq_o), 16'(e_nirq));
  endtask

  // Drive at negedge, update the model at the edge, compare at next negedge.
  task automatic step(input logic iss, input logic [2:0] op, input logic two,
                      input logic [15:0] a, input logic ci, input logic oi,
                      input logic [2:0] idx);
    logic [15:0] r;
    logic co, oo;
    issue_i = iss; op_i = op; amt_two_i = two; operand_i = a;
    c_i = ci; o_i = oi; reg_idx_i = idx;
    @(posedge clk);
    e_nirq = iss;
    if (iss) begin
      model(op, two, a, ci, oi, r, co, oo);
      e_res = r; e_c = co; e_o = oo;
      e_s = r[15]; e_z = (r == 16'h0); e_ill = (idx > 3'd3);
    end
    @(negedge clk);
    if (!iss) compare_all("R10", "R10");
    else compare_all(tag_of(op), (op[2] == 1'b0) ? "R6" : tag_of(op));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] lo, hi, nlo, nhi;
    logic [31:0] w;
    logic        fc, fo;
    rst_n = 1'b0; issue_i = 1'b0; op_i = 3'd0; amt_two_i = 1'b0;
    operand_i = 16'h0; c_i = 1'b0; o_i = 1'b0; reg_idx_i = 3'd0;
    e_res = '0; e_c = 0; e_o = 0; e_s = 0; e_z = 0; e_ill = 0; e_nirq = 0;
    repeat (3) @(negedge clk);
    // R11: reset state, even with an issue presented.
    issue_i = 1'b1; operand_i = 16'hFFFF; c_i = 1'b1; o_i = 1'b1;
    @(negedge clk);
    compare_all("R11", "R11");
    issue_i = 1'b0;
    rst_n = 1'b1;

    // Directed corners
    step(1, 3'd0, 1, 16'hC001, 1, 0, 3'd0);  // R1 zero fill left by 2
    step(1, 3'd1, 0, 16'h8001, 0, 1, 3'd1);  // R1 zero fill right
    step(1, 3'd2, 1, 16'h8004, 0, 0, 3'd2);  // R2 sign fill
    step(1, 3'd2, 0, 16'hFFFF, 1, 1, 3'd3);  // R2 -1 stays -1
    step(1, 3'd3, 0, 16'h12AB, 0, 0, 3'd0);  // R3 exchange
    step(1, 3'd3, 1, 16'h12AB, 1, 0, 3'd0);  // R3 low byte duplicated
    step(1, 3'd4, 0, 16'h8000, 0, 1, 3'd0);  // R4 overflow kept
    step(1, 3'd4, 1, 16'h4000, 1, 0, 3'd0);  // R4 bit14 to overflow, zero result
    step(1, 3'd5, 1, 16'h0002, 1, 0, 3'd0);  // R4 right into flags
    step(1, 3'd6, 1, 16'h0000, 1, 0, 3'd0);  // R5 fill order
    step(1, 3'd7, 1, 16'h0000, 0, 1, 3'd0);  // R5 fill order mirrored
    step(1, 3'd7, 0, 16'h0001, 1, 1, 3'd4);  // R5 and R8 illegal index
    step(0, 3'd0, 0, 16'hFFFF, 1, 1, 3'd7);  // R10 hold, R9 low
    step(0, 3'd6, 1, 16'h1234, 0, 0, 3'd5);  // R10 hold again

    // R12: 32-bit left shift by 2 through the flags
    lo = 16'hC35A; hi = 16'h9F0F;
    w  = {hi, lo} << 2;
    step(1, 3'd4, 1, lo, 0, 0, 3'd1);
    nlo = result_o; fc = c_o; fo = o_o;
    step(1, 3'd6, 1, hi, fc, fo, 3'd2);
    nhi = result_o;
    chk("R12", "left32", 16'(({nhi, nlo} == w) ? 1 : 0), 16'd1);

    // R12: 32-bit arithmetic right shift by 2 through the flags
    w  = 32'($signed({hi, lo}) >>> 2);
    step(1, 3'd5, 1, hi, 0, 0, 3'd3);
    nhi = result_o; fc = c_o; fo = o_o;
    step(1, 3'd7, 1, lo, fc, fo, 3'd0);
    nlo = result_o;
    chk("R12", "right32", 16'(({nhi, nlo} == w) ? 1 : 0), 16'd1);

    // Random mix over every code, amount, flag and index
    for (int k = 0; k < 600; k++) begin
      step(1'($urandom_range(0, 4) != 0), 3'($urandom), 1'($urandom),
           16'($urandom), 1'($urandom), 1'($urandom), 3'($urandom));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule